// File: doc/BRIEF.md
# DMA descriptor table controller

This block steers one direction of a DMA engine from a table of descriptors kept in local memory. Software fills a table whose first dword is a header and whose entries sit at a fixed 32-byte stride after it. It then programs the table locations, the index of the last entry and a descriptor count through a 32-bit register slave, and sets a start bit. The block fetches each entry dword by dword through a single-outstanding read master, stamps the entry with its ID and offers it as a 160-bit descriptor on a valid/ready stream.

A data mover consumes each descriptor and returns short status words. The block counts off completions strictly in ID order. When the completion for the last index arrives, it writes that ID into the header dword of the host-side table through a write master. If software asked for it, the block then raises a one-cycle interrupt request. The busy flag covers the whole sequence, and the register file is locked while busy is set, so one run cannot be disturbed by a half-applied reprogramming.

Top module: `dtab_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 control, 0x04 status (read-only), 0x08/0x0C host table base low/high, 0x10 last index (bits [7:0]), 0x14/0x18 local table base low/high. Control reads back count in [7:0] and interrupt enable in bit 9. The start bit 8 and bits [31:10] always read 0. Any other offset reads 0, and writes to offsets that are not a multiple of 4 are ignored. Read data appears in the cycle after the read strobe.
- R2: A control write with bit 8 set starts a run only if the written count is non-zero and the last index register equals count−1. Otherwise the block stays idle and issues no read.
- R3: Dword k (0..4) of entry n is read from local base + 32·(n+1) + 4·k, in ascending n then k. Each read is a single dword, the request is held with a stable address until granted, and only one read is outstanding.
- R4: Entry n goes out as one descriptor with dword k in bits [32k+31:32k] and the ID n ORed into bits [159:152]; the table keeps those bits zero. Descriptors leave in ascending ID order, and each is held stable until accepted.
- R5: A status word (bit 8 = completed, bits [7:0] = ID) counts only if it is completed and carries the next expected ID, starting from 0. Every other word is ignored and does not end the run.
- R6: After the completion for the last index, exactly one dword write goes to the host table base with the last index zero-extended as data. The request is held stable until acknowledged.
- R7: When control bit 9 is set, irq pulses high for exactly one cycle, the cycle after the write-back is acknowledged. Otherwise irq stays low.
- R8: Status bit 9 (busy) is set from an accepted start until the write-back is acknowledged. Bit 8 is set by the first counted completion and cleared by a start. Bits [7:0] give the ID of the entry being fetched or last issued.
- R9: While busy, writes to every register are ignored.
- R10: After reset all registers read 0 and no request, descriptor or interrupt is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | 5 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, one cycle after csr_rd |
| mrd_req | output | 1 | Table read request |
| mrd_addr | output | 64 | Table read byte address |
| mrd_gnt | input | 1 | Table read request accepted |
| mrd_rvalid | input | 1 | Table read data valid |
| mrd_rdata | input | 32 | Table read data |
| desc_valid | output | 1 | Descriptor valid |
| desc_ready | input | 1 | Descriptor accepted by the mover |
| desc_data | output | 160 | Descriptor payload |
| sts_valid | input | 1 | Status word valid |
| sts_word | input | 9 | Status: bit 8 completed, bits [7:0] ID |
| mwr_req | output | 1 | Header write-back request |
| mwr_addr | output | 64 | Header write-back byte address |
| mwr_data | output | 32 | Header write-back data |
| mwr_ack | input | 1 | Header write-back accepted |
| irq | output | 1 | One-cycle completion interrupt request |

## Verification
Runs sweep descriptor counts from 1 to 12 with different table bases. Each run uses either free-flowing handshakes or periodic stalls on the read grant, descriptor ready and write acknowledge, which separates address and ordering bugs from handshake-hold bugs. Before the true completions, every run feeds a status word without its completed bit and one with an out-of-range ID. A design that matches loosely ends early and is caught. Illegal starts (zero count, mismatched last index) and reprogramming attempts during a run show whether the start gate and the busy lock hold.

// File: rtl/dtab_pkg.sv
`timescale 1ns/1ps
// Shared constants and state types for the descriptor table controller.
package dtab_pkg;
    // Register word indexes (byte offset / 4)
    localparam int unsigned IDX_CTRL  = 0;
    localparam int unsigned IDX_STAT  = 1;
    localparam int unsigned IDX_HB_LO = 2;
    localparam int unsigned IDX_HB_HI = 3;
    localparam int unsigned IDX_LAST  = 4;
    localparam int unsigned IDX_LB_LO = 5;
    localparam int unsigned IDX_LB_HI = 6;

    // Bit positions that software and the mover decode
    localparam int unsigned CTL_START  = 8;
    localparam int unsigned CTL_IRQ_EN = 9;

    typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT, F_PUSH} fetch_state_e;
    typedef enum logic [1:0] {T_IDLE, T_RUN, T_WB} track_state_e;
endpackage

// File: rtl/dtab_regs.sv
`timescale 1ns/1ps
// Register slave. Holds table bases, last index, count and interrupt enable,
// and emits a one-cycle go pulse for a legal start.
// Assumes: AW == 2*DW, ID_W + 2 <= DW; writes are blocked while the engine is busy.
module dtab_regs
    import dtab_pkg::*;
#(
    parameter int DW     = 32,
    parameter int ID_W   = 8,
    parameter int AW     = 64,
    parameter int CSR_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic              csr_rd,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [DW-1:0]     csr_wdata,
    output logic [DW-1:0]     csr_rdata,
    input  logic              eng_busy,
    input  logic [ID_W-1:0]   cur_id,
    input  logic              done_flag,
    output logic              go,
    output logic              irq_en,
    output logic [ID_W-1:0]   last_idx,
    output logic [AW-1:0]     host_base,
    output logic [AW-1:0]     local_base
);
    localparam int WSEL_W = CSR_AW - 2;
    localparam int NBASE  = 4;

    // Maps base slot 0..3 to its register word index
    function automatic int unsigned slot_reg(input int s);
        return (s < 2) ? IDX_HB_LO + s : IDX_LB_LO + s - 2;
    endfunction

    logic [WSEL_W-1:0] wsel;
    logic              aligned;
    logic              wr_ok;
    logic              busy_all;
    logic [ID_W-1:0]   desc_cnt;
    logic [ID_W-1:0]   wr_cnt;
    logic [DW-1:0]     base_q [NBASE];
    logic [DW-1:0]     rd_mux;

    assign wsel     = csr_addr[CSR_AW-1:2];
    assign aligned  = (csr_addr[1:0] == 2'b00);
    assign busy_all = eng_busy | go;
    assign wr_ok    = csr_wr & aligned & ~busy_all;
    assign wr_cnt   = csr_wdata[ID_W-1:0];

    // Base address halves, one register per slot
    for (genvar s = 0; s < NBASE; s++) begin : g_base
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[s] <= '0;
            else if (wr_ok && wsel == WSEL_W'(slot_reg(s)))
                base_q[s] <= csr_wdata;
        end
    end

    assign host_base  = {base_q[1], base_q[0]};
    assign local_base = {base_q[3], base_q[2]};

    // Control fields and gated, self-clearing start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_cnt <= '0;
            irq_en   <= 1'b0;
            go       <= 1'b0;
        end else begin
            go <= 1'b0;
            if (wr_ok && wsel == WSEL_W'(IDX_CTRL)) begin
                desc_cnt <= wr_cnt;
                irq_en   <= csr_wdata[CTL_IRQ_EN];
                go       <= csr_wdata[CTL_START] && (wr_cnt != '0) &&
                            (last_idx == wr_cnt - 1'b1);
            end
        end
    end

    // Last index register
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_idx <= '0;
        else if (wr_ok && wsel == WSEL_W'(IDX_LAST))
            last_idx <= wr_cnt;
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            case (wsel)
                WSEL_W'(IDX_CTRL):  rd_mux = {{(DW-ID_W-2){1'b0}}, irq_en, 1'b0, desc_cnt};
                WSEL_W'(IDX_STAT):  rd_mux = {{(DW-ID_W-2){1'b0}}, busy_all, done_flag, cur_id};
                WSEL_W'(IDX_HB_LO): rd_mux = base_q[0];
                WSEL_W'(IDX_HB_HI): rd_mux = base_q[1];
                WSEL_W'(IDX_LAST):  rd_mux = {{(DW-ID_W){1'b0}}, last_idx};
                WSEL_W'(IDX_LB_LO): rd_mux = base_q[2];
                WSEL_W'(IDX_LB_HI): rd_mux = base_q[3];
                default:            rd_mux = '0;
            endcase
        end
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)
            csr_rdata <= '0;
        else if (csr_rd)
            csr_rdata <= rd_mux;
    end
endmodule

// File: rtl/dtab_fetch.sv
`timescale 1ns/1ps
// Entry fetcher. Reads each table entry one dword at a time, assembles it,
// stamps the ID into the top byte and offers it on the descriptor stream.
// Assumes: table entries keep the top ID_W bits of their last dword at zero.
module dtab_fetch
    import dtab_pkg::*;
#(
    parameter int DW       = 32,
    parameter int ID_W     = 8,
    parameter int AW       = 64,
    parameter int DESC_DW  = 5,
    parameter int STRIDE_B = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [ID_W-1:0]       last_idx,
    input  logic [AW-1:0]         local_base,
    output logic                  mrd_req,
    output logic [AW-1:0]         mrd_addr,
    input  logic                  mrd_gnt,
    input  logic                  mrd_rvalid,
    input  logic [DW-1:0]         mrd_rdata,
    output logic                  desc_valid,
    input  logic                  desc_ready,
    output logic [DW*DESC_DW-1:0] desc_data,
    output logic [ID_W-1:0]       cur_id,
    output logic                  busy
);
    localparam int WORD_W    = $clog2(DESC_DW);
    localparam int STRIDE_SH = $clog2(STRIDE_B);
    localparam int BYTE_SH   = $clog2(DW / 8);

    fetch_state_e      st;
    logic [ID_W-1:0]   idx;
    logic [WORD_W-1:0] wsel;
    logic              last_word;
    logic [AW-1:0]     entry_off;
    logic [AW-1:0]     word_off;

    assign last_word = (wsel == WORD_W'(DESC_DW - 1));
    assign entry_off = (AW'(idx) + AW'(1)) << STRIDE_SH;
    assign word_off  = AW'(wsel) << BYTE_SH;

    // Fetch sequencing: request, wait for data, push entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= F_IDLE;
            idx  <= '0;
            wsel <= '0;
        end else begin
            case (st)
                F_IDLE: if (go) begin
                    idx  <= '0;
                    wsel <= '0;
                    st   <= F_REQ;
                end
                F_REQ: if (mrd_gnt) st <= F_WAIT;
                F_WAIT: if (mrd_rvalid) begin
                    if (last_word) begin
                        wsel <= '0;
                        st   <= F_PUSH;
                    end else begin
                        wsel <= wsel + 1'b1;
                        st   <= F_REQ;
                    end
                end
                F_PUSH: if (desc_ready) begin
                    if (idx == last_idx) begin
                        st <= F_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= F_REQ;
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // Entry assembly buffer, one register per dword
    for (genvar g = 0; g < DESC_DW; g++) begin : g_word
        logic [DW-1:0] keep;
        always_ff @(posedge clk) begin
            if (!rst_n)
                keep <= '0;
            else if (st == F_WAIT && mrd_rvalid && wsel == WORD_W'(g))
                keep <= mrd_rdata;
        end
        if (g == DESC_DW - 1) begin : g_ctl
            assign desc_data[g*DW +: DW] = keep | {idx, {(DW-ID_W){1'b0}}};
        end else begin : g_dat
            assign desc_data[g*DW +: DW] = keep;
        end
    end

    assign mrd_req    = (st == F_REQ);
    assign mrd_addr   = local_base + entry_off + word_off;
    assign desc_valid = (st == F_PUSH);
    assign cur_id     = idx;
    assign busy       = (st != F_IDLE);
endmodule

// File: rtl/dtab_track.sv
`timescale 1ns/1ps
// Completion tracker. Counts status words in ID order, writes the last ID
// into the host table header and pulses the interrupt request.
// Assumes: last_idx and irq_en stay constant while busy.
module dtab_track
    import dtab_pkg::*;
#(
    parameter int DW   = 32,
    parameter int ID_W = 8,
    parameter int AW   = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [ID_W-1:0] last_idx,
    input  logic [AW-1:0]   host_base,
    input  logic            irq_en,
    input  logic            sts_valid,
    input  logic [ID_W:0]   sts_word,
    output logic            mwr_req,
    output logic [AW-1:0]   mwr_addr,
    output logic [DW-1:0]   mwr_data,
    input  logic            mwr_ack,
    output logic            irq,
    output logic            busy,
    output logic            done_flag
);
    track_state_e    st;
    logic [ID_W-1:0] exp_id;
    logic            hit;

    assign hit = (st == T_RUN) && sts_valid && sts_word[ID_W] &&
                 (sts_word[ID_W-1:0] == exp_id);

    // Run sequencing: wait completions, write back, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= T_IDLE;
            exp_id    <= '0;
            done_flag <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= 1'b0;
            case (st)
                T_IDLE: if (go) begin
                    exp_id    <= '0;
                    done_flag <= 1'b0;
                    st        <= T_RUN;
                end
                T_RUN: if (hit) begin
                    done_flag <= 1'b1;
                    if (exp_id == last_idx) st <= T_WB;
                    else                    exp_id <= exp_id + 1'b1;
                end
                T_WB: if (mwr_ack) begin
                    irq <= irq_en;
                    st  <= T_IDLE;
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    assign mwr_req  = (st == T_WB);
    assign mwr_addr = host_base;
    assign mwr_data = {{(DW-ID_W){1'b0}}, last_idx};
    assign busy     = (st != T_IDLE);
endmodule

// File: rtl/dtab_ctrl.sv
`timescale 1ns/1ps
// Descriptor table controller top: register slave, entry fetcher and
// completion tracker for one DMA direction.
// Assumes: a single clock domain and a table laid out at a fixed stride.
module dtab_ctrl #(
    parameter int DW       = 32,
    parameter int ID_W     = 8,
    parameter int AW       = 64,
    parameter int CSR_AW   = 5,
    parameter int DESC_DW  = 5,
    parameter int STRIDE_B = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  csr_wr,
    input  logic                  csr_rd,
    input  logic [CSR_AW-1:0]     csr_addr,
    input  logic [DW-1:0]         csr_wdata,
    output logic [DW-1:0]         csr_rdata,
    output logic                  mrd_req,
    output logic [AW-1:0]         mrd_addr,
    input  logic                  mrd_gnt,
    input  logic                  mrd_rvalid,
    input  logic [DW-1:0]         mrd_rdata,
    output logic                  desc_valid,
    input  logic                  desc_ready,
    output logic [DW*DESC_DW-1:0] desc_data,
    input  logic                  sts_valid,
    input  logic [ID_W:0]         sts_word,
    output logic                  mwr_req,
    output logic [AW-1:0]         mwr_addr,
    output logic [DW-1:0]         mwr_data,
    input  logic                  mwr_ack,
    output logic                  irq
);
    logic            go;
    logic            irq_en;
    logic [ID_W-1:0] last_idx;
    logic [AW-1:0]   host_base;
    logic [AW-1:0]   local_base;
    logic [ID_W-1:0] cur_id;
    logic            done_flag;
    logic            fetch_busy;
    logic            track_busy;
    logic            eng_busy;

    assign eng_busy = fetch_busy | track_busy;

    dtab_regs #(.DW(DW), .ID_W(ID_W), .AW(AW), .CSR_AW(CSR_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .eng_busy(eng_busy), .cur_id(cur_id), .done_flag(done_flag),
        .go(go), .irq_en(irq_en), .last_idx(last_idx),
        .host_base(host_base), .local_base(local_base)
    );

    dtab_fetch #(.DW(DW), .ID_W(ID_W), .AW(AW), .DESC_DW(DESC_DW), .STRIDE_B(STRIDE_B)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go(go), .last_idx(last_idx), .local_base(local_base),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt),
        .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
        .cur_id(cur_id), .busy(fetch_busy)
    );

    dtab_track #(.DW(DW), .ID_W(ID_W), .AW(AW)) u_track (
        .clk(clk), .rst_n(rst_n), .go(go), .last_idx(last_idx), .host_base(host_base),
        .irq_en(irq_en), .sts_valid(sts_valid), .sts_word(sts_word),
        .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data), .mwr_ack(mwr_ack),
        .irq(irq), .busy(track_busy), .done_flag(done_flag)
    );
endmodule

// File: rtl/dtab_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for dtab_ctrl, attached by bind.
module dtab_ctrl_chk #(
    parameter int DW      = 32,
    parameter int AW      = 64,
    parameter int DESC_DW = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mrd_req,
    input logic [AW-1:0]         mrd_addr,
    input logic                  mrd_gnt,
    input logic                  desc_valid,
    input logic                  desc_ready,
    input logic [DW*DESC_DW-1:0] desc_data,
    input logic                  mwr_req,
    input logic [AW-1:0]         mwr_addr,
    input logic [DW-1:0]         mwr_data,
    input logic                  mwr_ack,
    input logic                  irq,
    input logic                  busy
);
    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_req && !mrd_gnt |=> mrd_req && $stable(mrd_addr));
    // R3
    rd_vs_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mrd_req && desc_valid));
    // R4
    desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_data));
    // R6
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mwr_req && !mwr_ack |=> mwr_req && $stable(mwr_addr) && $stable(mwr_data));
    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R7
    irq_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mwr_req && mwr_ack));
    // R8
    wb_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mwr_req |-> busy);
    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(mwr_req && mwr_ack));
endmodule

bind dtab_ctrl dtab_ctrl_chk #(.DW(DW), .AW(AW), .DESC_DW(DESC_DW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
    .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data), .mwr_ack(mwr_ack),
    .irq(irq), .busy(eng_busy)
);

// File: tb/dtab_ctrl_tb.sv
`timescale 1ns/1ps
module dtab_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         csr_wr = 1'b0, csr_rd = 1'b0;
    logic [4:0]   csr_addr = '0;
    logic [31:0]  csr_wdata = '0, csr_rdata;
    logic         mrd_req, mrd_gnt = 1'b0, mrd_rvalid = 1'b0;
    logic [63:0]  mrd_addr;
    logic [31:0]  mrd_rdata = '0;
    logic         desc_valid, desc_ready = 1'b0;
    logic [159:0] desc_data;
    logic         sts_valid = 1'b0;
    logic [8:0]   sts_word = '0;
    logic         mwr_req, mwr_ack = 1'b0, irq;
    logic [63:0]  mwr_addr;
    logic [31:0]  mwr_data;

    always #2.5 clk = ~clk;

    dtab_ctrl u_dut (.*);

    int checks = 0, fails = 0, cyc = 0;
    int rn = 0, rk = 0, dn = 0, wbn = 0, irqn = 0, ncnt = 0, gmode = 0;
    logic [63:0] lb = '0, hb = '0, rd_q = '0;
    bit          rd_pend = 1'b0;
    logic [8:0]  sq [64];
    int          sq_w = 0, sq_r = 0;

    function automatic logic [31:0] memf(input logic [63:0] a);
        logic [31:0] v;
        v = {a[15:0] ^ 16'h3C5A, a[15:0] ^ a[47:32] ^ 16'h0F0F};
        if (a[4:2] == 3'd4) v[31:24] = 8'h00;
        return v;
    endfunction

    function automatic logic [159:0] exp_desc(input logic [63:0] b, input int n);
        logic [159:0] e;
        for (int k = 0; k < 5; k++) e[32*k +: 32] = memf(b + 64'(32*(n+1) + 4*k));
        e[159:152] = 8'(n);
        return e;
    endfunction

    task automatic check(input bit ok, input string rq, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Environment: memory, mover and write target, all driven at negedge
    always @(negedge clk) begin
        cyc++;
        mrd_rvalid = rd_pend;
        mrd_rdata  = memf(rd_q);
        rd_pend    = 1'b0;
        mrd_gnt    = (gmode == 0) ? 1'b1 : (cyc % 3 != 0);
        desc_ready = (gmode == 0) ? 1'b1 : (cyc % 4 != 1);
        mwr_ack    = (gmode == 0) ? 1'b1 : (cyc % 5 == 0);
        if (sq_r < sq_w) begin
            sts_valid = 1'b1; sts_word = sq[sq_r]; sq_r++;
        end else begin
            sts_valid = 1'b0; sts_word = '0;
        end
        if (mrd_req && mrd_gnt) begin
            // R3 address order
            check(mrd_addr == lb + 64'(32*(rn+1) + 4*rk), "R3", 160'(mrd_addr), 160'(lb + 64'(32*(rn+1) + 4*rk)));
            rd_pend = 1'b1; rd_q = mrd_addr;
            if (rk == 4) begin rk = 0; rn++; end else rk++;
        end
        if (desc_valid && desc_ready) begin
            check(desc_data == exp_desc(lb, dn), "R4", desc_data, exp_desc(lb, dn));
            dn++;
        end
        if (mwr_req && mwr_ack) begin
            check(mwr_addr == hb, "R6", 160'(mwr_addr), 160'(hb));
            check(mwr_data == 32'(ncnt - 1), "R6", 160'(mwr_data), 160'(ncnt - 1));
            wbn++;
        end
        if (irq) irqn++;
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic csr_write(input logic [4:0] a, input logic [31:0] d);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        tick();
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [4:0] a, output logic [31:0] d);
        csr_rd = 1'b1; csr_addr = a;
        tick();
        csr_rd = 1'b0;
        d = csr_rdata;
    endtask

    task automatic push_sts(input logic [8:0] w);
        sq[sq_w] = w; sq_w++;
    endtask

    task automatic run_case(input int i, input int cnt, input bit ie, input int gm);
        logic [31:0] r;
        lb = {32'h12 + 32'(i), 32'h400 + 32'(i) * 32'h10000};
        hb = {32'hABC0_0000 + 32'(i), 32'h8000 + 32'(i) * 32'h20};
        gmode = gm; rn = 0; rk = 0; dn = 0; wbn = 0; irqn = 0; ncnt = cnt;
        sq_w = 0; sq_r = 0;
        csr_write(5'h08, hb[31:0]);  csr_write(5'h0C, hb[63:32]);
        csr_write(5'h14, lb[31:0]);  csr_write(5'h18, lb[63:32]);
        csr_write(5'h10, 32'(cnt - 1));
        csr_write(5'h00, 32'(cnt) | 32'h100 | (32'(ie) << 9));
        while (dn < cnt) tick();
        repeat (3) tick();
        csr_read(5'h04, r);
        check(r == (32'h200 | 32'(cnt - 1)), "R8", 160'(r), 160'(32'h200 | 32'(cnt - 1)));
        // R9 attempts while busy
        csr_write(5'h00, 32'h107);
        csr_write(5'h10, 32'h55);
        // R5 ignored status words
        push_sts({1'b0, 8'd0});
        push_sts({1'b1, 8'(cnt)});
        repeat (10) tick();
        check(wbn == 0, "R5", 160'(wbn), 160'(0));
        csr_read(5'h04, r);
        check(r == (32'h200 | 32'(cnt - 1)), "R5", 160'(r), 160'(32'h200 | 32'(cnt - 1)));
        for (int j = 0; j < cnt; j++) push_sts({1'b1, 8'(j)});
        while (wbn < 1) tick();
        repeat (4) tick();
        check(wbn == 1, "R6", 160'(wbn), 160'(1));
        check(irqn == int'(ie), "R7", 160'(irqn), 160'(ie));
        check(rn == cnt && rk == 0, "R3", 160'(rn), 160'(cnt));
        csr_read(5'h04, r);
        check(r == (32'h100 | 32'(cnt - 1)), "R8", 160'(r), 160'(32'h100 | 32'(cnt - 1)));
        csr_read(5'h00, r);
        check(r == (32'(cnt) | (32'(ie) << 9)), "R9", 160'(r), 160'(32'(cnt) | (32'(ie) << 9)));
        csr_read(5'h10, r);
        check(r == 32'(cnt - 1), "R9", 160'(r), 160'(cnt - 1));
    endtask

    initial begin : main
        logic [31:0] r;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 reset state
        check(!desc_valid && !mrd_req && !mwr_req && !irq, "R10",
              160'({desc_valid, mrd_req, mwr_req, irq}), 160'(0));
        csr_read(5'h00, r); check(r == 0, "R10", 160'(r), 160'(0));
        csr_read(5'h04, r); check(r == 0, "R10", 160'(r), 160'(0));
        csr_read(5'h18, r); check(r == 0, "R10", 160'(r), 160'(0));
        // R1 register map
        csr_write(5'h08, 32'h1111_2220); csr_write(5'h0C, 32'h3333_4444);
        csr_write(5'h14, 32'h5555_6660); csr_write(5'h18, 32'h7777_8888);
        csr_write(5'h10, 32'h0000_01AB);
        csr_read(5'h08, r); check(r == 32'h1111_2220, "R1", 160'(r), 160'(32'h1111_2220));
        csr_read(5'h0C, r); check(r == 32'h3333_4444, "R1", 160'(r), 160'(32'h3333_4444));
        csr_read(5'h14, r); check(r == 32'h5555_6660, "R1", 160'(r), 160'(32'h5555_6660));
        csr_read(5'h18, r); check(r == 32'h7777_8888, "R1", 160'(r), 160'(32'h7777_8888));
        csr_read(5'h10, r); check(r == 32'hAB, "R1", 160'(r), 160'(32'hAB));
        csr_write(5'h00, 32'hFFFF_FC03);
        csr_read(5'h00, r); check(r == 32'h3, "R1", 160'(r), 160'(32'h3));
        csr_read(5'h1C, r); check(r == 0, "R1", 160'(r), 160'(0));
        csr_write(5'h09, 32'hDEAD_BEEF);
        csr_read(5'h08, r); check(r == 32'h1111_2220, "R1", 160'(r), 160'(32'h1111_2220));
        // R2 illegal starts
        rn = 0;
        csr_write(5'h10, 32'd2);
        csr_write(5'h00, 32'h100);
        repeat (10) tick();
        csr_read(5'h04, r); check(r[9] == 1'b0, "R2", 160'(r), 160'(0));
        csr_write(5'h00, 32'h105);
        repeat (10) tick();
        csr_read(5'h04, r); check(r[9] == 1'b0, "R2", 160'(r), 160'(0));
        check(rn == 0 && rk == 0, "R2", 160'(rn), 160'(0));
        csr_read(5'h00, r); check(r == 32'h5, "R1", 160'(r), 160'(32'h5));
        // Sweep of counts, interrupt enables and stall patterns
        run_case(0, 1, 1'b1, 0);
        run_case(1, 2, 1'b0, 1);
        run_case(2, 3, 1'b1, 1);
        run_case(3, 4, 1'b0, 0);
        run_case(4, 7, 1'b1, 1);
        run_case(5, 12, 1'b0, 1);
        run_case(6, 3, 1'b0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule